// File: doc/BRIEF.md
# Configurable Disjoint Routing Switchbox

This block is one routing junction of a mesh-style programmable fabric. Four channels meet at it, one on each side (north, east, south, west), and each channel carries `W` tracks. Each bidirectional track is modelled as a separate inbound bus and outbound bus. A serially loaded configuration decides, for every outbound track, which inbound track drives it, or whether it is left undriven.

Connectivity is linearly populated and keeps each signal in its track domain. An outbound track with index `t` can take its value only from track `t` on one of the other three sides. Three choices from each of four sides, with the two directions of a pair sharing one physical switch, gives 6W switches, compared with 6W² for a full crossbar. Because a signal cannot move to another track index, some sets of routing requests cannot be met even when the channels have room for them. Those cases are left to the placement and routing software.

The configuration is loaded through a scan chain. A loaded setting is audited all the time. One output counts how many outbound tracks are driven. Another output flags any track index where two sides are set to drive each other, because that pair of switches would short one wire onto itself. The data path has no registers.

Top module: `cfg_switchbox`

## Requirements
- R1: A synchronous active-high `rst` clears every configuration bit. After reset all outbound tracks are 0, `active_links` is 0 and `cfg_illegal` is 0.
- R2: While `cfg_en` is 1, each rising clock edge shifts the chain one place: `cfg_in` enters bit 0 and every other bit moves up one position. `cfg_out` always shows bit 8W-1 of the chain.
- R3: While `cfg_en` is 1, every outbound track on all four sides is held at 0, whatever the inbound tracks carry.
- R4: The selection for outbound side `s`, track `t` is the 2-bit field at chain bits [2·(s·W+t)+1 : 2·(s·W+t)]. Sides are numbered N=0, E=1, S=2, W=3, and their outbound buses are `out_n`, `out_e`, `out_s`, `out_w`. Code 0 drives 0. Code k (1 to 3) copies inbound side (s+k) mod 4, track `t`.
- R5: Outbound track `t` never depends on any inbound track with an index other than `t`.
- R6: `cfg_illegal` is 1 exactly when, for some track index `t`, side A selects side B and side B selects side A.
- R7: `active_links` equals the number of outbound tracks whose selection field is non-zero, in the range 0 to 4W.
- R8: While `cfg_en` is 0, the chain keeps its contents, and changes on `cfg_in` have no effect on outputs or on `cfg_out`.
- R9: The path from inbound to outbound tracks has no registers. A change on an inbound track shows on the outbound track it drives within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the chain; forces all outbound tracks to 0 |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (chain MSB) |
| in_n | input | W | Inbound tracks, north side |
| in_e | input | W | Inbound tracks, east side |
| in_s | input | W | Inbound tracks, south side |
| in_w | input | W | Inbound tracks, west side |
| out_n | output | W | Outbound tracks, north side |
| out_e | output | W | Outbound tracks, east side |
| out_s | output | W | Outbound tracks, south side |
| out_w | output | W | Outbound tracks, west side |
| active_links | output | $clog2(4W+1) | Count of driven outbound tracks |
| cfg_illegal | output | 1 | Mutual-drive conflict present in the configuration |

## Verification
A configuration can be shifted in while the inbound tracks keep changing. The bench provokes this in every load by drawing new random inbound values on each shift cycle. It expects all outbound tracks to stay at 0 in every one of those cycles, and it expects `cfg_out` to follow its own model of the chain bit by bit. Once `cfg_en` drops, the newly loaded selections must take effect at once, and the audit outputs must match the new setting in that same cycle. The bench checks this against expected outputs it computes from the field encoding and from random inbound patterns.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    localparam int NUM_SIDES = 4;
    localparam int SEL_BITS  = 2;

    typedef enum logic [1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

    typedef logic [SEL_BITS-1:0] sel_t;

    localparam sel_t SEL_OFF = 2'd0;

    // Bit offset of the selection field for a given side and track.
    function automatic int field_lsb(input int side, input int track, input int width);
        return SEL_BITS * (side * width + track);
    endfunction

    // Inbound side reached from outbound side `dst` by code `sel` (mod 4 wrap).
    function automatic side_e source_of(input side_e dst, input sel_t sel);
        return side_e'(2'(dst) + sel);
    endfunction

    // True when outbound side `dst` with code `sel` takes its value from `src`.
    function automatic logic picks(input side_e dst, input sel_t sel, input side_e src);
        return (sel != SEL_OFF) && (source_of(dst, sel) == src);
    endfunction

endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
    parameter int NB = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          ser_in,
    output logic          ser_out,
    output logic [NB-1:0] bits_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (shift_en) begin
            bits_q <= {bits_q[NB-2:0], ser_in};
        end
    end

    assign ser_out = bits_q[NB-1];
endmodule

// File: rtl/sbox_track_mux.sv
module sbox_track_mux
    import sbox_pkg::*;
#(
    parameter int W  = 8,
    localparam int NB = NUM_SIDES * W * SEL_BITS
) (
    input  logic [NB-1:0]                 cfg_bits,
    input  logic                          hold_off,
    input  logic [NUM_SIDES-1:0][W-1:0]   in_sides,
    output logic [NUM_SIDES-1:0][W-1:0]   out_sides
);
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        for (genvar t = 0; t < W; t++) begin : g_trk
            localparam int LSB = SEL_BITS * (s * W + t);
            sel_t  sel;
            side_e src;
            assign sel = cfg_bits[LSB +: SEL_BITS];
            assign src = source_of(side_e'(s), sel);
            always_comb begin
                if (hold_off || sel == SEL_OFF) begin
                    out_sides[s][t] = 1'b0;
                end else begin
                    out_sides[s][t] = in_sides[src][t];
                end
            end
        end
    end
endmodule

// File: rtl/sbox_cfg_audit.sv
module sbox_cfg_audit
    import sbox_pkg::*;
#(
    parameter int W  = 8,
    localparam int NB    = NUM_SIDES * W * SEL_BITS,
    localparam int CNT_W = $clog2(NUM_SIDES * W + 1)
) (
    input  logic [NB-1:0]    cfg_bits,
    output logic [CNT_W-1:0] link_count,
    output logic             conflict
);
    logic [W-1:0] trk_conflict;

    for (genvar t = 0; t < W; t++) begin : g_trk
        always_comb begin
            trk_conflict[t] = 1'b0;
            for (int a = 0; a < NUM_SIDES; a++) begin
                for (int b = a + 1; b < NUM_SIDES; b++) begin
                    if (picks(side_e'(a), cfg_bits[field_lsb(a, t, W) +: SEL_BITS], side_e'(b)) &&
                        picks(side_e'(b), cfg_bits[field_lsb(b, t, W) +: SEL_BITS], side_e'(a))) begin
                        trk_conflict[t] = 1'b1;
                    end
                end
            end
        end
    end

    assign conflict = |trk_conflict;

    always_comb begin
        link_count = '0;
        for (int f = 0; f < NUM_SIDES * W; f++) begin
            if (cfg_bits[SEL_BITS*f +: SEL_BITS] != SEL_OFF) begin
                link_count = link_count + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cfg_switchbox.sv
module cfg_switchbox
    import sbox_pkg::*;
#(
    parameter int W = 8,
    localparam int NB    = NUM_SIDES * W * SEL_BITS,
    localparam int CNT_W = $clog2(NUM_SIDES * W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_in,
    output logic             cfg_out,
    input  logic [W-1:0]     in_n,
    input  logic [W-1:0]     in_e,
    input  logic [W-1:0]     in_s,
    input  logic [W-1:0]     in_w,
    output logic [W-1:0]     out_n,
    output logic [W-1:0]     out_e,
    output logic [W-1:0]     out_s,
    output logic [W-1:0]     out_w,
    output logic [CNT_W-1:0] active_links,
    output logic             cfg_illegal
);
    logic [NB-1:0]                   cfg_bits;
    logic [NUM_SIDES-1:0][W-1:0]     in_sides;
    logic [NUM_SIDES-1:0][W-1:0]     out_sides;

    assign in_sides[SIDE_N] = in_n;
    assign in_sides[SIDE_E] = in_e;
    assign in_sides[SIDE_S] = in_s;
    assign in_sides[SIDE_W] = in_w;

    sbox_cfg_chain #(.NB(NB)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .ser_in   (cfg_in),
        .ser_out  (cfg_out),
        .bits_q   (cfg_bits)
    );

    sbox_track_mux #(.W(W)) u_mux (
        .cfg_bits  (cfg_bits),
        .hold_off  (cfg_en),
        .in_sides  (in_sides),
        .out_sides (out_sides)
    );

    sbox_cfg_audit #(.W(W)) u_audit (
        .cfg_bits   (cfg_bits),
        .link_count (active_links),
        .conflict   (cfg_illegal)
    );

    assign out_n = out_sides[SIDE_N];
    assign out_e = out_sides[SIDE_E];
    assign out_s = out_sides[SIDE_S];
    assign out_w = out_sides[SIDE_W];
endmodule

// File: rtl/sbox_chk.sv
module sbox_chk #(
    parameter int W = 8,
    localparam int NB    = 8 * W,
    localparam int CNT_W = $clog2(4 * W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic             cfg_in,
    input logic             cfg_out,
    input logic [NB-1:0]    cfg_bits,
    input logic [W-1:0]     out_n,
    input logic [W-1:0]     out_e,
    input logic [W-1:0]     out_s,
    input logic [W-1:0]     out_w,
    input logic [CNT_W-1:0] active_links,
    input logic             cfg_illegal
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (active_links == '0) && !cfg_illegal && (cfg_bits == '0)); // R1

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst) cfg_en |=> cfg_bits[0] == $past(cfg_in)); // R2

    AST_SHIFT_EXIT: assert property (@(posedge clk) disable iff (rst) cfg_en |=> cfg_out == $past(cfg_bits[NB-2])); // R2

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst) cfg_en |-> ({out_n, out_e, out_s, out_w} == '0)); // R3

    AST_CFG_RETAIN: assert property (@(posedge clk) disable iff (rst) !cfg_en |=> $stable(cfg_bits)); // R8

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst) active_links <= CNT_W'(4 * W)); // R7

    AST_CONFLICT_PAIR: assert property (@(posedge clk) disable iff (rst) cfg_illegal |-> active_links >= CNT_W'(2)); // R6
endmodule

bind cfg_switchbox sbox_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_en       (cfg_en),
    .cfg_in       (cfg_in),
    .cfg_out      (cfg_out),
    .cfg_bits     (cfg_bits),
    .out_n        (out_n),
    .out_e        (out_e),
    .out_s        (out_s),
    .out_w        (out_w),
    .active_links (active_links),
    .cfg_illegal  (cfg_illegal)
);

// File: tb/cfg_switchbox_tb.sv
`timescale 1ns/1ps
module cfg_switchbox_tb;
    localparam int W     = 8;
    localparam int NB    = 8 * W;
    localparam int CNT_W = $clog2(4 * W + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b0;
    logic cfg_in = 1'b0;
    logic cfg_out;
    logic [3:0][W-1:0] ins_v = '0;
    logic [W-1:0] out_n, out_e, out_s, out_w;
    logic [CNT_W-1:0] active_links;
    logic cfg_illegal;

    int total = 0;
    int bad   = 0;
    logic [NB-1:0] model = '0;
    bit done = 0;

    always #5 clk = ~clk;

    cfg_switchbox #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
        .in_n(ins_v[0]), .in_e(ins_v[1]), .in_s(ins_v[2]), .in_w(ins_v[3]),
        .out_n(out_n), .out_e(out_e), .out_s(out_s), .out_w(out_w),
        .active_links(active_links), .cfg_illegal(cfg_illegal)
    );

    function automatic logic [1:0] fld(input logic [NB-1:0] c, input int s, input int t);
        return c[2*(s*W+t) +: 2];
    endfunction

    function automatic logic [4*W-1:0] exp_outs(input logic [NB-1:0] c, input logic [3:0][W-1:0] iv, input logic hold);
        logic [3:0][W-1:0] o;
        o = '0;
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < W; t++) begin
                int k;
                k = int'(fld(c, s, t));
                if (!hold && k != 0) o[s][t] = iv[(s + k) % 4][t];
            end
        end
        return {o[3], o[2], o[1], o[0]};
    endfunction

    function automatic int exp_count(input logic [NB-1:0] c);
        int n = 0;
        for (int f = 0; f < 4 * W; f++) if (c[2*f +: 2] != 2'd0) n++;
        return n;
    endfunction

    function automatic logic exp_illegal(input logic [NB-1:0] c);
        for (int t = 0; t < W; t++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    int ka, kb;
                    ka = int'(fld(c, a, t));
                    kb = int'(fld(c, b, t));
                    if (a != b && ka != 0 && kb != 0 && (a + ka) % 4 == b && (b + kb) % 4 == a) return 1'b1;
                end
            end
        end
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [4*W-1:0] outs_now();
        return {out_w, out_s, out_e, out_n};
    endfunction

    // Shift a new setting in; inbound tracks churn every cycle (R2, R3).
    task automatic load(input logic [NB-1:0] c);
        @(negedge clk);
        cfg_en = 1'b1;
        for (int i = NB - 1; i >= 0; i--) begin
            cfg_in = c[i];
            ins_v = {$urandom, $urandom};
            #1;
            check("R3_hold", 64'(outs_now()), 64'(0));
            check("R2_out", 64'(cfg_out), 64'(model[NB-1]));
            @(negedge clk);
            model = {model[NB-2:0], c[i]};
        end
        cfg_en = 1'b0;
        #1;
        check("R2_final", 64'(cfg_out), 64'(c[NB-1]));
    endtask

    task automatic verify(input logic [NB-1:0] c, input int pats);
        check("R7_count", 64'(active_links), 64'(exp_count(c)));
        check("R6_illegal", 64'(cfg_illegal), 64'(exp_illegal(c)));
        for (int p = 0; p < pats; p++) begin
            ins_v = {$urandom, $urandom};
            #1;
            // R4 field decode, R5 per-index domain, R9 same-cycle path
            check("R4_R5_R9_route", 64'(outs_now()), 64'(exp_outs(c, ins_v, 1'b0)));
        end
    endtask

    initial begin
        logic [NB-1:0] c;
        logic [4*W-1:0] snap;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        ins_v = {$urandom, $urandom};
        #1;
        check("R1_outs", 64'(outs_now()), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        check("R1_count", 64'(active_links), 64'(0));
        check("R1_illegal", 64'(cfg_illegal), 64'(0));
        check("R1_cfgout", 64'(cfg_out), 64'(0));

        // Directed: every field code 3 -> side s copies side s-1, no mutual pair.
        c = {NB/2{2'b11}};
        load(c); verify(c, 4);
        check("R6_code3", 64'(cfg_illegal), 64'(0));
        // Directed: every field code 2 -> opposite sides drive each other.
        c = {NB/2{2'b10}};
        load(c); verify(c, 4);
        check("R6_code2", 64'(cfg_illegal), 64'(1));
        // Directed: single mutual pair N<->E on track W-1 only.
        c = '0;
        c[2*(0*W+W-1) +: 2] = 2'd1;
        c[2*(1*W+W-1) +: 2] = 2'd3;
        load(c); verify(c, 4);
        check("R6_single", 64'(cfg_illegal), 64'(1));
        check("R7_single", 64'(active_links), 64'(2));
        // Directed: domain isolation, only track 0 of N selects S.
        c = '0;
        c[1:0] = 2'd2;
        load(c);
        ins_v = '0; ins_v[2] = {W{1'b1}} & ~W'(1);
        #1;
        check("R5_domain", 64'(outs_now()), 64'(0));
        ins_v[2][0] = 1'b1;
        #1;
        check("R9_comb", 64'(out_n), 64'(1));

        // R8: cfg_in toggling with cfg_en low has no effect.
        c = {$urandom, $urandom};
        load(c);
        ins_v = {$urandom, $urandom};
        #1;
        snap = outs_now();
        for (int k = 0; k < 6; k++) begin
            cfg_in = ~cfg_in;
            @(negedge clk);
            check("R8_outs", 64'(outs_now()), 64'(snap));
            check("R8_cfgout", 64'(cfg_out), 64'(c[NB-1]));
        end
        verify(c, 2);

        // Random configurations.
        for (int r = 0; r < 40; r++) begin
            c = {$urandom, $urandom};
            load(c);
            verify(c, 6);
        end

        // R1 again: reset mid-setting clears everything.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        #1;
        check("R1_reclear", 64'(outs_now()), 64'(0));
        check("R1_recount", 64'(active_links), 64'(0));

        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired got=running exp=finished");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule